// File: doc/BRIEF.md
# Two-Stage Programmable Clock Divider

This block turns a fast oscillator clock into a slower output clock by dividing it twice in a row. The first stage is a high-speed divider. It uses one of six ratios, picked by a sparse 3-bit code. The second stage is an output divider. Its ratio is taken from a 7-bit code as code plus one. That stage passes the high-speed clock straight through (ratio 1) or divides it by an even number up to 128. A requested odd ratio above 1 is raised to the next even value. The output period is the fast-clock period multiplied by the product of the two applied ratios.

Both codes are sampled into a pending set on a one-cycle load strobe. The pending set becomes active only at the next rising edge of the output clock. The period in flight therefore always finishes with the ratios it began with, and no shortened pulse reaches the output. A high-speed code outside the legal set is refused: the high-speed ratio stays as it was, and a sticky error flag is raised. The output code in the same strobe is still taken.

Odd high-speed ratios are balanced by a half-cycle stretch. A copy of the rising-edge phase is taken on the falling edge of the fast clock and ORed in. The high time is then exactly half the period when measured in half fast-clock cycles.

Top module: `cdv_two_stage_div`

## Requirements
- R1: While `rst_n` is low, `clk_out` and `hs_code_err` are 0. After release, with the default codes (high-speed 000, output 0), `clk_out` rises at the first fast-clock rising edge and has a period of 4 fast cycles.
- R2: The high-speed code map is 000→4, 001→5, 010→6, 011→7, 101→9 and 111→11. With output code 0, the output period equals that ratio in fast cycles.
- R3: The output-stage ratio is the 7-bit code plus one. Code 0 gives ratio 1, and code 9 gives ratio 10.
- R4: A ratio from R3 that is odd and greater than 1 is applied as the next even value. Code 2 gives 4, and code 126 gives 128.
- R5: The output period in fast cycles equals the high-speed ratio multiplied by the output-stage ratio.
- R6: For every ratio pair, `clk_out` is high for exactly half its period, counted in half fast-clock cycles. This includes odd high-speed ratios with output ratio 1.
- R7: Loading code 100 or 110 leaves the high-speed ratio unchanged, still applies the output code from the same strobe, and sets `hs_code_err`.
- R8: `hs_code_err` stays set through later legal loads and clears only on reset.
- R9: Codes are sampled on a fast-clock rising edge with `load_i` high. They take effect at the next rising edge of `clk_out`, and the period under way completes with the old ratios.
- R10: The largest setting, high-speed code 111 with output code 127, gives a period of 1408 fast cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast oscillator clock; both of its edges are used |
| rst_n | input | 1 | Asynchronous active-low reset |
| hs_code_i | input | 3 | High-speed stage ratio code |
| out_code_i | input | 7 | Output stage ratio code (ratio = code + 1, odd values rounded up) |
| load_i | input | 1 | Sample both codes into the pending set |
| clk_out | output | 1 | Divided output clock |
| hs_code_err | output | 1 | Sticky flag: an unused high-speed code was loaded |

## Verification
The bench builds the block with its default parameters: a 7-bit output code, reset codes of zero, and the odd-ratio duty stretch enabled. That configuration makes every legal high-speed ratio reachable, together with the full output range up to 128. The longest setting, 1408 cycles, is also reachable. The bench measures period and high time in half fast-clock cycles, so an odd high-speed ratio exposes a missing half-cycle stretch as an off-by-one high count. It issues a load partway through a 512-cycle period to show that the period under way keeps its old length.

// File: rtl/cdv_pkg.sv
package cdv_pkg;

  localparam int HS_CODE_W  = 3;
  localparam int HS_RATIO_W = 4;

  typedef logic [HS_CODE_W-1:0]  hs_code_t;
  typedef logic [HS_RATIO_W-1:0] hs_ratio_t;

  typedef struct packed {
    logic      ok;
    hs_ratio_t ratio;
  } hs_dec_t;

  // Sparse high-speed code map; two codes have no ratio.
  function automatic hs_dec_t hs_decode(hs_code_t code);
    hs_dec_t d;
    d.ok = 1'b1;
    case (code)
      3'b000:  d.ratio = 4'd4;
      3'b001:  d.ratio = 4'd5;
      3'b010:  d.ratio = 4'd6;
      3'b011:  d.ratio = 4'd7;
      3'b101:  d.ratio = 4'd9;
      3'b111:  d.ratio = 4'd11;
      default: begin
        d.ok    = 1'b0;
        d.ratio = 4'd4;
      end
    endcase
    return d;
  endfunction

  // Output ratio from code: code + 1, odd results above one pushed up.
  function automatic int out_ratio_of(int code);
    int r;
    r = code + 1;
    if (r > 1 && (r % 2) == 1) r = r + 1;
    return r;
  endfunction

endpackage

// File: rtl/cdv_ratio_ctl.sv
module cdv_ratio_ctl
  import cdv_pkg::*;
#(
  parameter int                      OUT_CODE_W    = 7,
  parameter int                      OUT_RATIO_W   = OUT_CODE_W + 1,
  parameter hs_ratio_t               RST_HS_RATIO  = 4'd4,
  parameter logic [OUT_RATIO_W-1:0]  RST_OUT_RATIO = 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load_i,
  input  hs_code_t               hs_code_i,
  input  logic [OUT_CODE_W-1:0]  out_code_i,
  input  logic                   boundary_i,
  output hs_ratio_t              hs_ratio_o,
  output logic [OUT_RATIO_W-1:0] out_ratio_o,
  output logic                   code_err_o
);

  hs_dec_t                hs_dec;
  logic [OUT_RATIO_W-1:0] req_ratio;
  logic [OUT_RATIO_W-1:0] out_round;

  hs_ratio_t              hs_pend_q;
  logic [OUT_RATIO_W-1:0] out_pend_q;

  assign hs_dec    = hs_decode(hs_code_i);
  assign req_ratio = {1'b0, out_code_i} + OUT_RATIO_W'(1);
  assign out_round = (req_ratio[0] && (req_ratio != OUT_RATIO_W'(1)))
                     ? req_ratio + OUT_RATIO_W'(1) : req_ratio;

  // Pending set and sticky error flag.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_pend_q  <= RST_HS_RATIO;
      out_pend_q <= RST_OUT_RATIO;
      code_err_o <= 1'b0;
    end else if (load_i) begin
      out_pend_q <= out_round;
      if (hs_dec.ok) hs_pend_q <= hs_dec.ratio;
      else           code_err_o <= 1'b1;
    end
  end

  // Active set moves only at an output rising edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_ratio_o  <= RST_HS_RATIO;
      out_ratio_o <= RST_OUT_RATIO;
    end else if (boundary_i) begin
      hs_ratio_o  <= hs_pend_q;
      out_ratio_o <= out_pend_q;
    end
  end

endmodule

// File: rtl/cdv_hs_stage.sv
module cdv_hs_stage #(
  parameter int                  RATIO_W      = 4,
  parameter logic [RATIO_W-1:0]  RST_RATIO    = 4,
  parameter bit                  ODD_DUTY_FIX = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic               hs_clk_o,
  output logic               hs_wrap_o
);

  logic [RATIO_W-1:0] cnt_q;
  logic [RATIO_W-1:0] cnt_inc;
  logic [RATIO_W-1:0] half;
  logic               pos_q;

  assign cnt_inc   = cnt_q + RATIO_W'(1);
  assign half      = ratio_i >> 1;
  assign hs_wrap_o = (cnt_q == ratio_i - RATIO_W'(1));

  // Rising-edge phase: high for floor(ratio/2) fast cycles.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= RATIO_W'(RST_RATIO - 1);
      pos_q <= 1'b0;
    end else if (hs_wrap_o) begin
      cnt_q <= '0;
      pos_q <= 1'b1;
    end else begin
      cnt_q <= cnt_inc;
      pos_q <= (cnt_inc < half);
    end
  end

  generate
    if (ODD_DUTY_FIX) begin : g_odd_fix
      logic neg_q;
      // Falling-edge copy adds half a fast cycle to odd ratios.
      always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) neg_q <= 1'b0;
        else        neg_q <= pos_q;
      end
      assign hs_clk_o = pos_q | (neg_q & ratio_i[0]);
    end else begin : g_no_fix
      assign hs_clk_o = pos_q;
    end
  endgenerate

endmodule

// File: rtl/cdv_out_stage.sv
module cdv_out_stage #(
  parameter int                  RATIO_W   = 8,
  parameter logic [RATIO_W-1:0]  RST_RATIO = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic               hs_clk_i,
  input  logic               hs_wrap_i,
  output logic               clk_o,
  output logic               out_wrap_o
);

  logic [RATIO_W-1:0] oc_q;
  logic [RATIO_W-1:0] oc_inc;
  logic [RATIO_W-1:0] half;
  logic               lvl_q;
  logic               bypass;

  assign oc_inc     = oc_q + RATIO_W'(1);
  assign half       = ratio_i >> 1;
  assign bypass     = (ratio_i == RATIO_W'(1));
  assign out_wrap_o = (oc_q == ratio_i - RATIO_W'(1));

  // Counts high-speed periods; the level changes only on their rising edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oc_q  <= RATIO_W'(RST_RATIO - 1);
      lvl_q <= 1'b0;
    end else if (hs_wrap_i) begin
      if (out_wrap_o) begin
        oc_q  <= '0;
        lvl_q <= 1'b1;
      end else begin
        oc_q  <= oc_inc;
        lvl_q <= (oc_inc < half);
      end
    end
  end

  assign clk_o = bypass ? hs_clk_i : lvl_q;

endmodule

// File: rtl/cdv_two_stage_div.sv
module cdv_two_stage_div
  import cdv_pkg::*;
#(
  parameter int       OUT_CODE_W   = 7,
  parameter hs_code_t RST_HS_CODE  = 3'b000,
  parameter int       RST_OUT_CODE = 0,
  parameter bit       ODD_DUTY_FIX = 1'b1
) (
  input  logic                  clk_fast,
  input  logic                  rst_n,
  input  logic [2:0]            hs_code_i,
  input  logic [OUT_CODE_W-1:0] out_code_i,
  input  logic                  load_i,
  output logic                  clk_out,
  output logic                  hs_code_err
);

  localparam int                     OUT_RATIO_W   = OUT_CODE_W + 1;
  localparam hs_dec_t                RST_HS_DEC    = hs_decode(RST_HS_CODE);
  localparam hs_ratio_t              RST_HS_RATIO  = RST_HS_DEC.ratio;
  localparam logic [OUT_RATIO_W-1:0] RST_OUT_RATIO =
    OUT_RATIO_W'(out_ratio_of(RST_OUT_CODE));

  hs_ratio_t              hs_ratio_act;
  logic [OUT_RATIO_W-1:0] out_ratio_act;
  logic                   hs_clk;
  logic                   hs_wrap;
  logic                   out_wrap;
  logic                   boundary;

  assign boundary = hs_wrap & out_wrap;

  cdv_ratio_ctl #(
    .OUT_CODE_W    (OUT_CODE_W),
    .OUT_RATIO_W   (OUT_RATIO_W),
    .RST_HS_RATIO  (RST_HS_RATIO),
    .RST_OUT_RATIO (RST_OUT_RATIO)
  ) u_ctl (
    .clk         (clk_fast),
    .rst_n       (rst_n),
    .load_i      (load_i),
    .hs_code_i   (hs_code_i),
    .out_code_i  (out_code_i),
    .boundary_i  (boundary),
    .hs_ratio_o  (hs_ratio_act),
    .out_ratio_o (out_ratio_act),
    .code_err_o  (hs_code_err)
  );

  cdv_hs_stage #(
    .RATIO_W      (HS_RATIO_W),
    .RST_RATIO    (RST_HS_RATIO),
    .ODD_DUTY_FIX (ODD_DUTY_FIX)
  ) u_hs (
    .clk       (clk_fast),
    .rst_n     (rst_n),
    .ratio_i   (hs_ratio_act),
    .hs_clk_o  (hs_clk),
    .hs_wrap_o (hs_wrap)
  );

  cdv_out_stage #(
    .RATIO_W   (OUT_RATIO_W),
    .RST_RATIO (RST_OUT_RATIO)
  ) u_out (
    .clk        (clk_fast),
    .rst_n      (rst_n),
    .ratio_i    (out_ratio_act),
    .hs_clk_i   (hs_clk),
    .hs_wrap_i  (hs_wrap),
    .clk_o      (clk_out),
    .out_wrap_o (out_wrap)
  );

endmodule

// File: rtl/cdv_two_stage_div_chk.sv
module cdv_two_stage_div_chk #(
  parameter int OUT_RATIO_W = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   load_i,
  input logic [2:0]             hs_code_i,
  input logic                   code_err_i,
  input logic                   boundary_i,
  input logic [3:0]             hs_ratio_i,
  input logic [OUT_RATIO_W-1:0] out_ratio_i
);

  p_ratio_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary_i |=> ($stable(hs_ratio_i) && $stable(out_ratio_i)));

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    code_err_i |=> code_err_i);

  p_err_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(code_err_i) |-> ($past(load_i) &&
      (($past(hs_code_i) == 3'b100) || ($past(hs_code_i) == 3'b110))));

  p_out_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_ratio_i == OUT_RATIO_W'(1)) ||
    (!out_ratio_i[0] && (out_ratio_i != '0)));

  p_hs_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_ratio_i inside {4'd4, 4'd5, 4'd6, 4'd7, 4'd9, 4'd11}));

endmodule

bind cdv_two_stage_div cdv_two_stage_div_chk #(.OUT_RATIO_W(OUT_RATIO_W)) u_chk (
  .clk         (clk_fast),
  .rst_n       (rst_n),
  .load_i      (load_i),
  .hs_code_i   (hs_code_i),
  .code_err_i  (hs_code_err),
  .boundary_i  (boundary),
  .hs_ratio_i  (hs_ratio_act),
  .out_ratio_i (out_ratio_act)
);

// File: tb/sim_cdv_two_stage_div.sv
`timescale 1ns/1ps
module sim_cdv_two_stage_div;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] hs_code = 3'b000;
  logic [6:0] out_code = 7'd0;
  logic       load = 1'b0;
  logic       clk_out;
  logic       err;

  int  n_chk = 0;
  int  n_bad = 0;
  int  cyc = 0;
  logic prev_s = 1'b0;
  logic cur_s = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  cdv_two_stage_div u0 (
    .clk_fast    (clk),
    .rst_n       (rst_n),
    .hs_code_i   (hs_code),
    .out_code_i  (out_code),
    .load_i      (load),
    .clk_out     (clk_out),
    .hs_code_err (err)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cyc);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // One sample 1 ns after every fast-clock edge.
  task automatic step();
    @(posedge clk or negedge clk);
    #1;
    prev_s = cur_s;
    cur_s  = clk_out;
  endtask

  task automatic wait_rise();
    do step(); while (!(!prev_s && cur_s));
  endtask

  task automatic count_period(input int per0, input int hi0,
                              output int per, output int hi);
    per = per0;
    hi  = hi0;
    forever begin
      step();
      if (!prev_s && cur_s) break;
      per++;
      if (cur_s) hi++;
    end
  endtask

  // Period and high time in half fast cycles; expectation in fast cycles.
  task automatic check_period(input string req, input int exp_cyc);
    int per, hi;
    wait_rise();
    count_period(1, 1, per, hi);
    check(per == 2 * exp_cyc, req, "period half-cycles", per, 2 * exp_cyc);
    check(hi == exp_cyc, "R6", "high half-cycles", hi, exp_cyc);
  endtask

  task automatic load_codes(input logic [2:0] hs, input logic [6:0] oc);
    hs_code  = hs;
    out_code = oc;
    load     = 1'b1;
    step();
    step();
    load     = 1'b0;
    wait_rise();
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (6) begin
      step();
      check(clk_out == 1'b0, "R1", "clk_out in reset", clk_out, 0);
    end
    check(err == 1'b0, "R1", "err in reset", err, 0);
    hs_code  = 3'b000;
    out_code = 7'd0;
    rst_n = 1'b1;
    check_period("R1", 4);
  endtask

  task automatic t_hs_map();
    load_codes(3'b001, 7'd0); check_period("R2", 5);
    load_codes(3'b010, 7'd0); check_period("R2", 6);
    load_codes(3'b011, 7'd0); check_period("R2", 7);
    load_codes(3'b101, 7'd0); check_period("R2", 9);
    load_codes(3'b111, 7'd0); check_period("R2", 11);
    load_codes(3'b000, 7'd0); check_period("R2", 4);
  endtask

  task automatic t_out_ratio();
    load_codes(3'b000, 7'd1);   check_period("R3", 8);
    load_codes(3'b000, 7'd9);   check_period("R3", 40);
    load_codes(3'b000, 7'd2);   check_period("R4", 16);
    load_codes(3'b000, 7'd126); check_period("R4", 512);
    load_codes(3'b000, 7'd0);   check_period("R3", 4);
  endtask

  task automatic t_product();
    load_codes(3'b111, 7'd3);   check_period("R5", 44);
    load_codes(3'b011, 7'd5);   check_period("R5", 42);
    load_codes(3'b101, 7'd0);   check_period("R6", 9);
    load_codes(3'b111, 7'd127); check_period("R10", 1408);
  endtask

  task automatic t_unused();
    load_codes(3'b010, 7'd0); check_period("R7", 6);
    load_codes(3'b100, 7'd1); check_period("R7", 12);
    check(err == 1'b1, "R7", "err after code 100", err, 1);
    load_codes(3'b110, 7'd0); check_period("R7", 6);
    load_codes(3'b011, 7'd0); check_period("R8", 7);
    check(err == 1'b1, "R8", "err after legal load", err, 1);
  endtask

  task automatic t_boundary();
    int per, hi;
    load_codes(3'b000, 7'd127);
    wait_rise();
    hs_code  = 3'b001;
    out_code = 7'd0;
    load     = 1'b1;
    per = 1;
    hi  = 1;
    repeat (2) begin
      step();
      per++;
      if (cur_s) hi++;
    end
    load = 1'b0;
    count_period(per, hi, per, hi);
    check(per == 1024, "R9", "period with load mid-way", per, 1024);
    check(hi == 512, "R9", "high with load mid-way", hi, 512);
    count_period(1, 1, per, hi);
    check(per == 10, "R9", "first new period", per, 10);
    check(hi == 5, "R9", "first new high", hi, 5);
  endtask

  task automatic t_reset_clears();
    t_reset();
    check(err == 1'b0, "R8", "err after reset", err, 0);
  endtask

  initial begin
    t_reset();
    t_hs_map();
    t_out_ratio();
    t_product();
    t_unused();
    t_boundary();
    t_reset_clears();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule